// File: doc/BRIEF.md
# Sequential Unsigned Long Divider with Fit Check

This block divides an unsigned double-width dividend by a single-width divisor and returns a single-width quotient and remainder. The dividend arrives as two words: an upper word and a lower word. The divisor is one word. When the division completes, the quotient replaces the upper word and the remainder replaces the lower word.

The first thing the block does after a start is a range test. The quotient fits in one word only when the divisor is strictly greater than the upper dividend word. If the test fails, the block raises an overflow flag, finishes at once and returns both dividend words unchanged. A zero divisor always fails the test, so it is reported as an overflow. If the test passes, the block runs one restoring shift-subtract step per clock until every quotient bit is resolved.

The handshake is simple. A start pulse is accepted only while the block is idle. A busy level covers the whole operation, and a single-cycle done pulse marks the moment the result words and the flag are valid.

Top module: `udiv_ovf`

## Requirements
- R1: After reset, `busy`, `done` and `ovf` are 0 and both result words are 0.
- R2: When the divisor is greater than the upper word, `done` brings `hi_out` = floor(D / `dvs_in`) and `lo_out` = D mod `dvs_in`, where D = `hi_in`·2^W + `lo_in`.
- R3: When the divisor is less than or equal to the upper word (this includes a divisor of 0), `done` comes with `ovf` = 1, `hi_out` equal to the `hi_in` that was accepted and `lo_out` equal to the accepted `lo_in`.
- R4: For a division that fits, `done` is high in the cycle that follows the (W+1)-th rising edge after the edge that accepted `start`, and `busy` is high from the accepting edge until that same edge.
- R5: For an overflow, `done` is high in the cycle after the first rising edge that follows the accepting edge, and no iteration is performed.
- R6: `done` is high for exactly one cycle per operation, and `busy` is low whenever `done` is high.
- R7: A `start` that arrives while `busy` is high is ignored. It neither changes the result of the operation in progress nor produces another `done`.
- R8: When the upper word is 0 and the divisor N is nonzero, the remainder lies between 0 and N-1 and the quotient equals `lo_in`/N.
- R9: On a division that fits, `ovf` is 0 at `done`. The result words and `ovf` hold their values until the next `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| hi_in | input | W | Upper dividend word |
| lo_in | input | W | Lower dividend word |
| dvs_in | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result words and flag are valid |
| ovf | output | 1 | The quotient would not fit; the words are returned unchanged |
| hi_out | output | W | Quotient, or the upper dividend word on overflow |
| lo_out | output | W | Remainder, or the lower dividend word on overflow |

## Verification
The bench targets the boundary of the fit test:
- A divisor equal to the upper word must overflow. A design that compares with greater-or-equal would go on to iterate and return a wrong quotient.
- A zero divisor must overflow. A design that misses this case would return a quotient of all ones.
- A divisor of one with a zero upper word must give an all-ones quotient. The largest dividend that fits must give an all-ones quotient with a remainder just below the divisor. A restoring step that drops the carry bit of its shifted partial remainder would get these wrong.

Starts are injected while the block is busy, including during the range-test cycle. A design that accepts them would corrupt its operands or produce an unexpected done. Latency is checked to the exact cycle on both paths, so a step counter that is off by one is caught.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

   // Controller phases of the divider
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_CHECK = 2'd1,
      PH_RUN   = 2'd2
   } udiv_phase_t;

endpackage

// File: rtl/udiv_fit_check.sv
// Decides whether a single-word quotient can hold the result:
// true only when the divisor is strictly above the upper dividend word.
module udiv_fit_check #(
   parameter int W          = 16,
   parameter bit CMP_BY_SUB = 1'b1
) (
   input  logic [W-1:0] hi,
   input  logic [W-1:0] dvs,
   output logic         fits
);

   generate
      if (CMP_BY_SUB) begin : g_borrow
         // hi - dvs borrows exactly when hi < dvs
         logic [W:0] diff;
         assign diff = {1'b0, hi} - {1'b0, dvs};
         assign fits = diff[W];
      end else begin : g_relational
         assign fits = (dvs > hi);
      end
   endgenerate

endmodule

// File: rtl/udiv_step.sv
// One restoring shift-subtract step on a {partial remainder, dividend bits} pair.
module udiv_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] rem,
   input  logic [W-1:0] quo,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] rem_n,
   output logic [W-1:0] quo_n
);

   logic [W:0] shifted;
   logic [W:0] trial;
   logic       take;

   // Widened by one bit so that the carry of the shift is kept
   assign shifted = {rem, quo[W-1]};
   assign trial   = shifted - {1'b0, dvs};
   assign take    = (shifted >= {1'b0, dvs});

   // The partial remainder stays below dvs, so W bits are enough
   assign rem_n = take ? trial[W-1:0] : shifted[W-1:0];
   assign quo_n = {quo[W-2:0], take};

endmodule

// File: rtl/udiv_ctrl.sv
// Sequencer: a range-test cycle, then W step cycles, then a done pulse.
module udiv_ctrl
   import udiv_pkg::*;
#(
   parameter int W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fits,
   output logic busy,
   output logic done,
   output logic load,
   output logic step,
   output logic last,
   output logic fail
);

   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

   udiv_phase_t   phase;
   logic [CW-1:0] idx;

   assign busy = (phase != PH_IDLE);
   assign load = (phase == PH_IDLE) && start;
   assign step = (phase == PH_RUN);
   assign last = step && (idx == LAST_IDX);
   assign fail = (phase == PH_CHECK) && !fits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) phase <= PH_CHECK;
            end
            PH_CHECK: begin
               idx <= '0;
               if (fits) begin
                  phase <= PH_RUN;
               end else begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end
            end
            PH_RUN: begin
               idx <= idx + 1'b1;
               if (idx == LAST_IDX) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/udiv_ovf.sv
// Unsigned 2W-by-W sequential divider with an up-front quotient-fit test.
module udiv_ovf #(
   parameter int W          = 16,
   parameter bit CMP_BY_SUB = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] hi_in,
   input  logic [W-1:0] lo_in,
   input  logic [W-1:0] dvs_in,
   output logic         busy,
   output logic         done,
   output logic         ovf,
   output logic [W-1:0] hi_out,
   output logic [W-1:0] lo_out
);

   generate
      if (W < 2) begin : g_bad_width
         $error("udiv_ovf: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] hi_q, lo_q, dvs_q;
   logic [W-1:0] rem_n, quo_n;
   logic         fits, load, step, last, fail;

   udiv_fit_check #(.W(W), .CMP_BY_SUB(CMP_BY_SUB)) u_fit (
      .hi   (hi_q),
      .dvs  (dvs_q),
      .fits (fits)
   );

   udiv_ctrl #(.W(W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .fits  (fits),
      .busy  (busy),
      .done  (done),
      .load  (load),
      .step  (step),
      .last  (last),
      .fail  (fail)
   );

   // During the steps, hi_q carries the partial remainder and lo_q
   // shifts dividend bits out and quotient bits in.
   udiv_step #(.W(W)) u_step (
      .rem   (hi_q),
      .quo   (lo_q),
      .dvs   (dvs_q),
      .rem_n (rem_n),
      .quo_n (quo_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         dvs_q <= '0;
         ovf   <= 1'b0;
      end else begin
         if (load) begin
            hi_q  <= hi_in;
            lo_q  <= lo_in;
            dvs_q <= dvs_in;
            ovf   <= 1'b0;
         end else if (fail) begin
            ovf <= 1'b1;
         end else if (last) begin
            // The final step swaps the pair into quotient-high order
            hi_q <= quo_n;
            lo_q <= rem_n;
         end else if (step) begin
            hi_q <= rem_n;
            lo_q <= quo_n;
         end
      end
   end

   assign hi_out = hi_q;
   assign lo_out = lo_q;

endmodule

// File: rtl/udiv_ovf_chk.sv
// Protocol and result checker bound to the divider.
module udiv_ovf_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [W-1:0] hi_in,
   input logic [W-1:0] lo_in,
   input logic [W-1:0] dvs_in,
   input logic         busy,
   input logic         done,
   input logic         ovf,
   input logic [W-1:0] hi_out,
   input logic [W-1:0] lo_out
);

   localparam int LW = $clog2(W + 4) + 1;

   logic [W-1:0]  cap_hi, cap_lo, cap_dvs;
   logic [LW-1:0] span;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_hi  <= '0;
         cap_lo  <= '0;
         cap_dvs <= '0;
         span    <= '0;
      end else begin
         if (start && !busy) begin
            cap_hi  <= hi_in;
            cap_lo  <= lo_in;
            cap_dvs <= dvs_in;
            span    <= LW'(1);
         end else if (busy) begin
            span <= span + 1'b1;
         end
      end
   end

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ovf) |-> (span == LW'(W + 2)));

   p_latency_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ovf) |-> (span == LW'(2)));

   p_ovf_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ovf == (cap_dvs <= cap_hi)));

   p_ovf_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ovf) |-> (hi_out == cap_hi && lo_out == cap_lo));

   p_rem_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ovf) |-> (lo_out < cap_dvs));

   p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(hi_out) && $stable(lo_out) && $stable(ovf)));

endmodule

bind udiv_ovf udiv_ovf_chk #(.W(W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .hi_in  (hi_in),
   .lo_in  (lo_in),
   .dvs_in (dvs_in),
   .busy   (busy),
   .done   (done),
   .ovf    (ovf),
   .hi_out (hi_out),
   .lo_out (lo_out)
);

// File: tb/sim_udiv_ovf.sv
`timescale 1ns/1ps
module sim_udiv_ovf;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] hi_in = '0, lo_in = '0, dvs_in = '0;
   logic         busy, done, ovf;
   logic [W-1:0] hi_out, lo_out;

   udiv_ovf #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .hi_in(hi_in), .lo_in(lo_in), .dvs_in(dvs_in),
      .busy(busy), .done(done), .ovf(ovf),
      .hi_out(hi_out), .lo_out(lo_out)
   );

   always #4 clk = ~clk;   // 125 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [W-1:0] hi;
      logic [W-1:0] lo;
      logic [W-1:0] dvs;
      logic [W-1:0] src_hi;
      logic         ovf;
      int           due;
   } exp_t;

   exp_t sb[$];
   exp_t last_e;
   int   checks = 0;
   int   errors = 0;
   logic prev_done = 1'b0;
   logic [31:0] seed = 32'h1BADF00D;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   // Driver: wait until idle, present the operands for one cycle, push the expectation
   task automatic issue(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d);
      exp_t   e;
      longint dd;
      @(negedge clk);
      while (busy) @(negedge clk);
      dd       = (longint'(h) << W) | longint'(l);
      e.src_hi = h;
      e.dvs    = d;
      e.ovf    = (d <= h);
      if (e.ovf) begin
         e.hi  = h;
         e.lo  = l;
         e.due = cyc + 1 + 1;
      end else begin
         e.hi  = W'(dd / longint'(d));
         e.lo  = W'(dd % longint'(d));
         e.due = cyc + 1 + W + 1;
      end
      sb.push_back(e);
      start  = 1'b1;
      hi_in  = h;
      lo_in  = l;
      dvs_in = d;
      @(negedge clk);
      start  = 1'b0;
      hi_in  = ~h;
      lo_in  = ~l;
      dvs_in = d + 1'b1;
   endtask

   // Start pulse while busy: must be ignored (R7)
   task automatic poke(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d);
      chk(busy == 1'b1, "R7", "busy before poke", longint'(busy), 1);
      start  = 1'b1;
      hi_in  = h;
      lo_in  = l;
      dvs_in = d;
      @(negedge clk);
      start  = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      @(negedge clk);
      while ((sb.size() != 0 || busy) && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      repeat (2) @(negedge clk);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done)
            chk(done == 1'b0, "R6", "done wider than one cycle", longint'(done), 0);
         if (done) begin
            chk(busy == 1'b0, "R6", "busy with done", longint'(busy), 0);
            if (sb.size() == 0) begin
               chk(1'b0, "R7", "done without accepted start", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               last_e = e;
               chk(ovf == e.ovf, e.ovf ? "R3" : "R9", "ovf flag", longint'(ovf), longint'(e.ovf));
               chk(hi_out == e.hi, e.ovf ? "R3" : "R2", "hi_out", longint'(hi_out), longint'(e.hi));
               chk(lo_out == e.lo, e.ovf ? "R3" : "R2", "lo_out", longint'(lo_out), longint'(e.lo));
               chk(cyc == e.due, e.ovf ? "R5" : "R4", "done cycle", longint'(cyc), longint'(e.due));
               if (!e.ovf && e.src_hi == '0)
                  chk(lo_out < e.dvs, "R8", "remainder below divisor", longint'(lo_out), longint'(e.dvs));
            end
         end
         prev_done <= done;
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      summary();
      $finish;
   end

   initial begin
      logic [W-1:0] h_hold, l_hold;
      logic         o_hold;
      repeat (3) @(negedge clk);
      start = 1'b1;              // pulse during reset has no effect
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1", "busy", longint'(busy), 0);
      chk(done == 0, "R1", "done", longint'(done), 0);
      chk(ovf == 0, "R1", "ovf", longint'(ovf), 0);
      chk(hi_out == 0, "R1", "hi_out", longint'(hi_out), 0);
      chk(lo_out == 0, "R1", "lo_out", longint'(lo_out), 0);

      // R2 / R8 directed divisions that fit
      issue(16'h0000, 16'd100, 16'd7);
      issue(16'h1234, 16'h5678, 16'h2000);
      issue(16'h0000, 16'hFFFF, 16'h0001);   // all-ones quotient
      issue(16'hFFFE, 16'hFFFF, 16'hFFFF);   // largest fitting dividend
      issue(16'h0000, 16'h0003, 16'h0009);   // quotient zero
      // R3 / R5 overflow boundaries
      issue(16'h0005, 16'h0000, 16'h0005);   // divisor equals upper word
      issue(16'h0010, 16'h0001, 16'h0000);   // zero divisor
      issue(16'h0000, 16'h0005, 16'h0000);   // zero divisor, zero upper word
      issue(16'hFFFF, 16'hFFFF, 16'h0001);
      drain();

      // R7: starts while running a fitting division
      issue(16'h0003, 16'h0000, 16'h0100);
      poke(16'h0000, 16'h0001, 16'h0002);
      poke(16'hFFFF, 16'hFFFF, 16'h0000);
      repeat (4) @(negedge clk);
      poke(16'h0001, 16'h0002, 16'h0003);
      drain();
      // R7: start during the range-test cycle of an overflow
      issue(16'h0007, 16'h0007, 16'h0003);
      poke(16'h0000, 16'h0064, 16'h0009);
      drain();

      // R9: results hold after done
      issue(16'h00AB, 16'hCDEF, 16'h1000);
      drain();
      h_hold = hi_out;
      l_hold = lo_out;
      o_hold = ovf;
      repeat (6) @(negedge clk);
      chk(hi_out == last_e.hi && hi_out == h_hold, "R9", "hi_out held", longint'(hi_out), longint'(last_e.hi));
      chk(lo_out == last_e.lo && lo_out == l_hold, "R9", "lo_out held", longint'(lo_out), longint'(last_e.lo));
      chk(ovf == o_hold, "R9", "ovf held", longint'(ovf), longint'(o_hold));

      // Mixed pseudo-random operands, alternating fitting and free
      for (int i = 0; i < 40; i++) begin
         logic [31:0]  r1, r2;
         logic [W-1:0] h, l, d;
         r1 = rnd();
         r2 = rnd();
         h  = r1[15:0];
         l  = r1[31:16];
         d  = r2[15:0];
         if (i % 2 == 0) begin
            if (d == '0) d = 16'h0001;
            h = h % d;
         end
         if (i % 8 == 3) h = '0;
         issue(h, l, d);
      end
      drain();

      summary();
      $finish;
   end

endmodule